// File: doc/BRIEF.md
# Multi-Field Test Address Generator

This block produces the word addresses used by a memory traffic generator. The address word is cut into up to six contiguous bit fields. Each field has its own generator, which holds a constant, walks through values in programmable steps, or draws pseudo-random values. A field moves to a new value only once in every N requests, where N is set per field. Nested sweeps can be built this way, for example a column that moves on every request under a row that moves once every few hundred. A bank group or bank can also be pinned while the remaining bits roam.

A sequencer outside the block pulses `seq_start` to open a write or read sequence, `loop_go` at each new loop iteration, and `next_req` for every address it needs. The address comes back one cycle after the request, as a word address and also as a symbol address that is the word address shifted left by a fixed amount. The configuration is written through a small write-only register port. Write and read sequences each have their own start values and modes. Increments, update rates, field boundaries and the return-to-start flag are shared by both.

Top module: `mfield_addr_gen`

## Requirements
- R1: While `rst_n` is low and right after reset, `addr_valid` is 0 and `word_addr` and `sym_addr` are 0. Reset leaves every field unused (mode 3), sets every rate to 1, every increment and start value to 0, every top-bit index to AW-1, and clears the return flag.
- R2: A `next_req` pulse that does not coincide with a reload makes `addr_valid` high for exactly the following cycle, carrying the address in that cycle. With no request, `addr_valid` is low.
- R3: Field 0 covers bit 0 up to its top-bit index. Field k covers the bits from one above field k-1's top-bit index up to its own top-bit index. An index larger than AW-1 counts as AW-1. A field's value is placed with its bit 0 at the field's lowest bit. Bits covered by no active field are 0.
- R4: Mode 0 (fixed) presents the field's start value: the low register (group 0) gives bits 15:0 and the high register (group 1) gives bits 31:16, truncated to the field width.
- R5: Mode 2 (sequential) adds the field's 16-bit increment (group 3) each time the field updates, wrapping within the field width. Request i after a reload therefore sees start + floor(i/N)*increment.
- R6: The field's 16-bit rate N (group 4) makes it update after every N-th request. N=0 behaves as N=1.
- R7: Mode 1 (random) presents the low bits of a 32-bit LFSR owned by field k. The LFSR is seeded at reset with 0x5EED0000 | (k+1). Each time the field updates, the state s becomes (s>>1) XOR (s[0] ? 0x80200003 : 0). A reload leaves the LFSR unchanged.
- R8: `seq_start` clears every field's request counter, loads every field's start value from the bank selected by `seq_read` (0 write, 1 read), and makes that bank's modes active. A request in the same cycle yields no address.
- R9: `loop_go` reloads start values and clears counters when the return flag (group 6, bit 0) is 1. It has no effect on the address stream when the flag is 0.
- R10: Config writes address `cfg_idx` = {group[2:0], field[2:0]}. Groups 0, 1 and 2 (start low, start high, mode) go to the bank chosen by `cfg_rd_bank`. Groups 3, 4 and 5 (increment, rate, top-bit index) and group 6 are shared by both banks.
- R11: `sym_addr` equals `word_addr` shifted left by SYM_SHIFT (5) bits, in the same cycle.
- R12: Mode 3 (unused) contributes no bits, even when a later active field sits above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rd_bank | input | 1 | Bank for start/mode writes: 0 write, 1 read |
| cfg_idx | input | 6 | {group, field} register index |
| cfg_wdata | input | 16 | Configuration write data |
| seq_start | input | 1 | Open a sequence: reload all fields, select bank |
| seq_read | input | 1 | Bank chosen at `seq_start` |
| loop_go | input | 1 | New loop iteration marker |
| next_req | input | 1 | Request one address |
| addr_valid | output | 1 | Address presented this cycle |
| word_addr | output | AW | Word address |
| sym_addr | output | AW+SYM_SHIFT | Symbol address |

## Verification
The bench sweeps the rate through 0 to 4 with two increments on a 3-bit sequential field placed under a fixed field. An off-by-one in the update counter would show up as a shifted step, and a missing wrap would spill into the fixed field's bits. A random field is followed step by step against a bench-side LFSR at rate 2, so advancing on every request, or reseeding on reload, gives wrong values. Bank separation, start in the middle of a run, loop reloads with the flag clear and with it set, and an unused field sitting between active ones are each checked. Any of these done wrong shows up as stale values or stray bits.

// File: rtl/mfag_pkg.sv
package mfag_pkg;
  typedef enum logic [1:0] {
    FM_FIXED = 2'd0,
    FM_RAND  = 2'd1,
    FM_SEQ   = 2'd2,
    FM_OFF   = 2'd3
  } fmode_e;

  typedef enum logic [2:0] {
    G_ST_LO = 3'd0,
    G_ST_HI = 3'd1,
    G_MODE  = 3'd2,
    G_INCR  = 3'd3,
    G_FREQ  = 3'd4,
    G_MSB   = 3'd5,
    G_RET   = 3'd6,
    G_NONE  = 3'd7
  } cfg_grp_e;

  localparam int          CW             = 16;
  localparam logic [31:0] LFSR_TAPS      = 32'h8020_0003;
  localparam logic [31:0] LFSR_SEED_BASE = 32'h5EED_0000;

  // One Galois step of the per-field random source.
  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? LFSR_TAPS : 32'h0);
  endfunction

  // Mask with ones from bit lo to bit hi inclusive; empty if hi < lo.
  function automatic logic [31:0] span_mask(input int lo, input int hi);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 32; b++) begin
      if (b >= lo && b <= hi) m[b] = 1'b1;
    end
    return m;
  endfunction

  function automatic int clamp_msb(input int msb, input int aw);
    return (msb > aw - 1) ? aw - 1 : msb;
  endfunction
endpackage

// File: rtl/mfag_regs.sv
module mfag_regs
  import mfag_pkg::*;
#(
  parameter int AW = 26,
  parameter int NF = 6,
  parameter int MW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic                  bank,
  input  logic [5:0]            idx,
  input  logic [CW-1:0]         wdata,
  output logic [NF-1:0][31:0]   st_wr,
  output logic [NF-1:0][31:0]   st_rd,
  output logic [NF-1:0][1:0]    md_wr,
  output logic [NF-1:0][1:0]    md_rd,
  output logic [NF-1:0][CW-1:0] inc,
  output logic [NF-1:0][CW-1:0] frq,
  output logic [NF-1:0][MW-1:0] msb,
  output logic                  ret
);
  localparam logic [MW-1:0] MSB_RST = MW'(AW - 1);

  cfg_grp_e   grp;
  logic [2:0] fsel;
  assign grp  = cfg_grp_e'(idx[5:3]);
  assign fsel = idx[2:0];

  for (genvar k = 0; k < NF; k++) begin : g_fld
    localparam logic [2:0] KI = 3'(k);
    logic          hit;
    logic [31:0]   r_stw, r_str;
    logic [1:0]    r_mdw, r_mdr;
    logic [CW-1:0] r_inc, r_frq;
    logic [MW-1:0] r_msb;

    assign hit = we && (fsel == KI);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_stw <= '0;
        r_str <= '0;
        r_mdw <= FM_OFF;
        r_mdr <= FM_OFF;
        r_inc <= '0;
        r_frq <= CW'(1);
        r_msb <= MSB_RST;
      end else if (hit) begin
        case (grp)
          G_ST_LO: if (bank) r_str[15:0]  <= wdata; else r_stw[15:0]  <= wdata;
          G_ST_HI: if (bank) r_str[31:16] <= wdata; else r_stw[31:16] <= wdata;
          G_MODE:  if (bank) r_mdr <= wdata[1:0];   else r_mdw <= wdata[1:0];
          G_INCR:  r_inc <= wdata;
          G_FREQ:  r_frq <= wdata;
          G_MSB:   r_msb <= wdata[MW-1:0];
          default: ;
        endcase
      end
    end

    assign st_wr[k] = r_stw;
    assign st_rd[k] = r_str;
    assign md_wr[k] = r_mdw;
    assign md_rd[k] = r_mdr;
    assign inc[k]   = r_inc;
    assign frq[k]   = r_frq;
    assign msb[k]   = r_msb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ret <= 1'b0;
    else if (we && grp == G_RET && fsel == 3'd0) ret <= wdata[0];
  end
endmodule

// File: rtl/mfag_field.sv
module mfag_field
  import mfag_pkg::*;
#(
  parameter int AW = 26,
  parameter int K  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [31:0]   st,
  input  logic [CW-1:0] inc,
  input  logic [CW-1:0] frq,
  input  logic          load,
  input  logic          step,
  output logic [AW-1:0] val,
  output logic          upd
);
  localparam logic [31:0] SEED = LFSR_SEED_BASE | 32'(K + 1);

  logic [CW-1:0] cnt;
  logic [AW-1:0] value;
  logic [31:0]   lfsr;
  logic [CW:0]   eff_n;
  logic          hit;
  fmode_e        fm;

  assign fm    = fmode_e'(mode);
  assign eff_n = (frq == '0) ? (CW+1)'(1) : {1'b0, frq};
  assign hit   = ({1'b0, cnt} + (CW+1)'(1)) >= eff_n;
  assign upd   = step && !load && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      value <= '0;
      lfsr  <= SEED;
    end else if (load) begin
      cnt   <= '0;
      value <= st[AW-1:0];
    end else if (step) begin
      cnt <= hit ? '0 : cnt + CW'(1);
      if (hit) begin
        case (fm)
          FM_SEQ:  value <= value + AW'(inc);
          FM_RAND: lfsr  <= lfsr_next(lfsr);
          default: ;
        endcase
      end
    end
  end

  assign val = (fm == FM_RAND) ? lfsr[AW-1:0] : value;
endmodule

// File: rtl/mfag_merge.sv
module mfag_merge
  import mfag_pkg::*;
#(
  parameter int AW = 26,
  parameter int NF = 6,
  parameter int MW = 5
) (
  input  logic [NF-1:0][AW-1:0] vals,
  input  logic [NF-1:0][1:0]    modes,
  input  logic [NF-1:0][MW-1:0] msb,
  output logic [AW-1:0]         word
);
  logic [31:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NF; k++) begin
      int lo;
      int hi;
      lo = (k == 0) ? 0 : clamp_msb(int'(msb[k-1]), AW) + 1;
      hi = clamp_msb(int'(msb[k]), AW);
      if (modes[k] != FM_OFF)
        acc = acc | ((32'(vals[k]) << lo) & span_mask(lo, hi));
    end
    word = acc[AW-1:0];
  end
endmodule

// File: rtl/mfield_addr_gen.sv
module mfield_addr_gen
  import mfag_pkg::*;
#(
  parameter int AW        = 26,
  parameter int NF        = 6,
  parameter int SYM_SHIFT = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_rd_bank,
  input  logic [5:0]              cfg_idx,
  input  logic [15:0]             cfg_wdata,
  input  logic                    seq_start,
  input  logic                    seq_read,
  input  logic                    loop_go,
  input  logic                    next_req,
  output logic                    addr_valid,
  output logic [AW-1:0]           word_addr,
  output logic [AW+SYM_SHIFT-1:0] sym_addr
);
  localparam int MW = (AW > 1) ? $clog2(AW) : 1;

  logic [NF-1:0][31:0]   st_wr, st_rd, st_sel;
  logic [NF-1:0][1:0]    md_wr, md_rd, modes_act;
  logic [NF-1:0][CW-1:0] inc_cfg, frq_cfg;
  logic [NF-1:0][MW-1:0] msb_cfg;
  logic                  ret_flag;
  logic                  rd_act;
  logic                  load_bank;
  logic                  load_evt;
  logic                  step_evt;
  logic [NF-1:0]         upd_vec;
  logic [NF-1:0][AW-1:0] vals;
  logic [AW-1:0]         merged;

  mfag_regs #(.AW(AW), .NF(NF), .MW(MW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .bank(cfg_rd_bank),
    .idx(cfg_idx), .wdata(cfg_wdata),
    .st_wr(st_wr), .st_rd(st_rd), .md_wr(md_wr), .md_rd(md_rd),
    .inc(inc_cfg), .frq(frq_cfg), .msb(msb_cfg), .ret(ret_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_act <= 1'b0;
    else if (seq_start) rd_act <= seq_read;
  end

  assign load_bank = seq_start ? seq_read : rd_act;
  assign st_sel    = load_bank ? st_rd : st_wr;
  assign modes_act = rd_act ? md_rd : md_wr;
  assign load_evt  = seq_start || (loop_go && ret_flag);
  assign step_evt  = next_req && !load_evt;

  for (genvar k = 0; k < NF; k++) begin : g_gen
    mfag_field #(.AW(AW), .K(k)) u_fld (
      .clk(clk), .rst_n(rst_n), .mode(modes_act[k]), .st(st_sel[k]),
      .inc(inc_cfg[k]), .frq(frq_cfg[k]), .load(load_evt), .step(step_evt),
      .val(vals[k]), .upd(upd_vec[k])
    );
  end

  mfag_merge #(.AW(AW), .NF(NF), .MW(MW)) u_merge (
    .vals(vals), .modes(modes_act), .msb(msb_cfg), .word(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      word_addr  <= '0;
      sym_addr   <= '0;
    end else begin
      addr_valid <= step_evt;
      if (step_evt) begin
        word_addr <= merged;
        sym_addr  <= {merged, {SYM_SHIFT{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/mfag_chk.sv
module mfag_chk
  import mfag_pkg::*;
#(
  parameter int AW = 26,
  parameter int NF = 6,
  parameter int MW = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  next_req,
  input logic                  seq_start,
  input logic                  step_evt,
  input logic [NF-1:0]         upd_vec,
  input logic                  addr_valid,
  input logic [AW-1:0]         word_addr,
  input logic [NF-1:0][1:0]    modes_act,
  input logic [NF-1:0][MW-1:0] msb_cfg
);
  logic [AW-1:0] top_mask;
  logic [31:0]   tm;

  always_comb begin
    tm = '0;
    for (int k = 0; k < NF; k++)
      if (modes_act[k] != FM_OFF) tm = tm | span_mask(0, clamp_msb(int'(msb_cfg[k]), AW));
    top_mask = tm[AW-1:0];
  end

  assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> addr_valid);
  assert_valid_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> $past(next_req));
  assert_high_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> ((word_addr & ~$past(top_mask)) == '0));
  assert_update_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_vec) |-> step_evt);
  assert_start_blocks_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !addr_valid);
endmodule

bind mfield_addr_gen mfag_chk #(.AW(AW), .NF(NF), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .next_req(next_req), .seq_start(seq_start),
  .step_evt(step_evt), .upd_vec(upd_vec), .addr_valid(addr_valid),
  .word_addr(word_addr), .modes_act(modes_act), .msb_cfg(msb_cfg)
);

// File: tb/mfield_addr_gen_test.sv
module mfield_addr_gen_test;
  localparam int AW = 26;
  localparam int NF = 6;
  localparam int SS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_rd_bank = 1'b0, seq_start = 1'b0, seq_read = 1'b0;
  logic loop_go = 1'b0, next_req = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [15:0] cfg_wdata = '0;
  logic              addr_valid;
  logic [AW-1:0]     word_addr;
  logic [AW+SS-1:0]  sym_addr;

  mfield_addr_gen #(.AW(AW), .NF(NF), .SYM_SHIFT(SS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rd_bank(cfg_rd_bank),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .seq_start(seq_start),
    .seq_read(seq_read), .loop_go(loop_go), .next_req(next_req),
    .addr_valid(addr_valid), .word_addr(word_addr), .sym_addr(sym_addr)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 1'b0;

  // Bench-side model of configuration and field state
  logic [31:0] b_st [2][NF];
  logic [1:0]  b_md [2][NF];
  logic [15:0] b_inc [NF], b_frq [NF];
  int          b_msb [NF];
  logic        b_ret;
  logic [31:0] m_val [NF], m_lfsr [NF];
  int          m_cnt [NF];
  int          m_bank;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  function automatic logic [31:0] lfsr_adv(input logic [31:0] s);
    logic [31:0] r;
    r = s >> 1;
    if (s[0]) r = r ^ 32'h8020_0003;
    return r;
  endfunction

  function automatic int lim(input int m);
    return (m > AW - 1) ? AW - 1 : m;
  endfunction

  function automatic logic [AW-1:0] exp_word();
    logic [AW-1:0] w;
    logic [31:0]   v;
    int lo, hi;
    w = '0;
    for (int k = 0; k < NF; k++) begin
      lo = (k == 0) ? 0 : lim(b_msb[k-1]) + 1;
      hi = lim(b_msb[k]);
      v  = (b_md[m_bank][k] == 2'd1) ? m_lfsr[k] : m_val[k];
      if (b_md[m_bank][k] != 2'd3)
        for (int b = lo; b <= hi; b++) w[b] = v[b-lo];
    end
    return w;
  endfunction

  task automatic model_step();
    for (int k = 0; k < NF; k++) begin
      int n;
      n = (b_frq[k] == 0) ? 1 : int'(b_frq[k]);
      if (m_cnt[k] + 1 >= n) begin
        m_cnt[k] = 0;
        if (b_md[m_bank][k] == 2'd2) m_val[k] = m_val[k] + 32'(b_inc[k]);
        if (b_md[m_bank][k] == 2'd1) m_lfsr[k] = lfsr_adv(m_lfsr[k]);
      end else m_cnt[k]++;
    end
  endtask

  task automatic model_load(input int bank);
    m_bank = bank;
    for (int k = 0; k < NF; k++) begin
      m_cnt[k] = 0;
      m_val[k] = b_st[bank][k];
    end
  endtask

  // grp/fld form the register index {group, field} (R10)
  task automatic wr(input int bank, input int grp, input int fld, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rd_bank = bank[0];
    cfg_idx = {grp[2:0], fld[2:0]}; cfg_wdata = data[15:0];
    @(negedge clk);
    cfg_we = 1'b0;
    case (grp)
      0: b_st[bank][fld][15:0]  = data[15:0];
      1: b_st[bank][fld][31:16] = data[15:0];
      2: b_md[bank][fld] = data[1:0];
      3: b_inc[fld] = data[15:0];
      4: b_frq[fld] = data[15:0];
      5: b_msb[fld] = data[4:0];
      6: b_ret = data[0];
      default: ;
    endcase
  endtask

  task automatic set_field(input int bank, input int fld, input int mode, input int st,
                           input int inc, input int frq, input int msb);
    wr(bank, 0, fld, st & 16'hFFFF);
    wr(bank, 1, fld, (st >> 16) & 16'hFFFF);
    wr(bank, 2, fld, mode);
    wr(bank, 3, fld, inc);
    wr(bank, 4, fld, frq);
    wr(bank, 5, fld, msb);
  endtask

  task automatic all_off();
    for (int k = 0; k < NF; k++) begin
      wr(0, 2, k, 3);
      wr(1, 2, k, 3);
    end
  endtask

  task automatic start_seq(input int rd);
    @(negedge clk);
    seq_start = 1'b1; seq_read = rd[0];
    @(negedge clk);
    seq_start = 1'b0;
    model_load(rd);
  endtask

  task automatic loop_pulse();
    @(negedge clk);
    loop_go = 1'b1;
    @(negedge clk);
    loop_go = 1'b0;
    if (b_ret) model_load(m_bank);
  endtask

  task automatic do_req(input string req);
    logic [AW-1:0] e;
    e = exp_word();
    @(negedge clk);
    next_req = 1'b1;
    @(negedge clk);
    next_req = 1'b0;
    chk({req, " word"}, 64'(word_addr), 64'(e));
    chk("R11 sym", 64'(sym_addr), 64'({e, 5'b0}));
    chk("R2 valid", 64'(addr_valid), 64'd1);
    model_step();
  endtask

  initial begin
    for (int k = 0; k < NF; k++) begin
      b_st[0][k] = '0; b_st[1][k] = '0; b_md[0][k] = 2'd3; b_md[1][k] = 2'd3;
      b_inc[k] = '0; b_frq[k] = 16'd1; b_msb[k] = AW - 1;
      m_val[k] = '0; m_cnt[k] = 0; m_lfsr[k] = 32'h5EED_0000 | 32'(k + 1);
    end
    b_ret = 1'b0; m_bank = 0;

    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(addr_valid), 0);
    chk("R1 word in reset", 64'(word_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 64'(addr_valid), 0);
    chk("R1 sym after reset", 64'(sym_addr), 0);

    // R4 / R3: two fixed fields, 0x12345 over bits 25:4 and 5 in bits 3:0
    set_field(0, 0, 0, 32'h5, 0, 1, 3);
    set_field(0, 1, 0, 32'h12345, 0, 1, 25);
    start_seq(0);
    do_req("R4 fixed");
    chk("R4 fixed literal", 64'(word_addr), 64'((32'h12345 << 4) | 32'h5));
    do_req("R4 fixed repeat");
    @(negedge clk);
    chk("R2 idle valid low", 64'(addr_valid), 0);

    // R5 / R6 sweep: 3-bit sequential field under a fixed field
    for (int n = 0; n <= 4; n++) begin
      for (int ii = 0; ii < 2; ii++) begin
        int inc;
        inc = (ii == 0) ? 1 : 3;
        set_field(0, 0, 2, 5, inc, n, 2);
        set_field(0, 1, 0, 32'h3A, 0, 1, 9);
        start_seq(0);
        for (int r = 0; r < 9; r++) do_req(n == 0 ? "R6 rate zero" : "R5 R6 seq sweep");
      end
    end

    // R3 / R12: unused middle field, field 2 above it
    set_field(0, 0, 0, 32'h7, 0, 1, 2);
    set_field(0, 1, 3, 32'hFF, 0, 1, 6);
    set_field(0, 2, 2, 32'h1, 1, 1, 10);
    start_seq(0);
    for (int r = 0; r < 3; r++) do_req("R12 gap field");
    chk("R12 literal", 64'(word_addr), 64'((32'h3 << 7) | 32'h7));

    // R7: random field at rate 2, plus fixed bits above
    all_off();
    set_field(0, 0, 1, 0, 0, 2, 3);
    set_field(0, 1, 0, 32'h9, 0, 1, 7);
    start_seq(0);
    chk("R7 first value", 64'(exp_word()), 64'(32'h90 | (32'h5EED_0001 & 32'hF)));
    for (int r = 0; r < 8; r++) do_req("R7 random");

    // R10: separate banks, shared increment
    all_off();
    set_field(0, 0, 2, 32'h1, 2, 1, 7);
    set_field(1, 0, 0, 32'h9, 2, 1, 7);
    start_seq(1);
    do_req("R10 read bank");
    do_req("R10 read bank fixed");
    chk("R10 read literal", 64'(word_addr), 64'h9);
    start_seq(0);
    do_req("R10 write bank");
    do_req("R10 write bank seq");
    chk("R10 write literal", 64'(word_addr), 64'h3);

    // R8: restart in the middle of a run
    do_req("R8 before restart");
    start_seq(0);
    do_req("R8 after restart");
    chk("R8 literal", 64'(word_addr), 64'h1);

    // R9: loop reload off, then on
    do_req("R9 prep");
    loop_pulse();
    do_req("R9 flag clear continues");
    chk("R9 continue literal", 64'(word_addr), 64'h5);
    wr(0, 6, 0, 1);
    loop_pulse();
    do_req("R9 flag set reloads");
    chk("R9 reload literal", 64'(word_addr), 64'h1);

    finish_run();
  end
endmodule